// File: doc/BRIEF.md
# Message Object Transfer Engine

This block gives a host register bus indirect access to a small message-object RAM. Each object holds an arbitration word (whose top bit marks the object valid), a 16-bit control word (carrying a new-data flag and an interrupt-pending flag) and a 64-bit payload. The host never addresses that RAM directly. It first fills staging registers and a command-mask register. It then writes an object number into the request register. The engine raises a busy flag, waits a fixed number of cycles, and then moves the fields the mask selects in one direction: from staging into the object when the direction bit is set, or from the object into staging when it is clear.

In the read direction, two mask bits act on flags. One clears the object's new-data flag and the other clears its interrupt-pending flag, and both act after the fields have been copied out, so the staging copy shows the flags as they were. The RAM is not reset. Software is expected to sweep every object, writing zero arbitration and control and then clearing the flags, before it relies on any of them. A separate one-bit status interrupt is set by an event input and is acknowledged when the host reads the status register.

Register map (3-bit address): 0 request (write: object number in bits 7:0; read: busy in bit 15, last accepted number in bits 7:0), 1 command mask, 2 arbitration staging, 3 control staging (bits 15:0), 4 payload low word, 5 payload high word, 6 status (bit 0). Reads are combinational on the address.

Top module: `mo_xfer_engine`

## Requirements
- R1: After reset, busy is 0, the status interrupt is 0, and the request, mask, arbitration, control and payload registers all read 0.
- R2: A request write with a number from 1 to NUM_OBJ sets busy from the next cycle. Busy stays high for exactly XFER_CYCLES cycles (3 by default), and the transfer takes effect on the cycle busy falls. Object n is stored at index n-1, and its flags appear on bit n-1 of the flag vectors.
- R3: A request write with number 0 or greater than NUM_OBJ is ignored: busy stays 0 and the request register keeps its previous number.
- R4: A request write that arrives while busy is high is ignored: the transfer in flight keeps its object, and the other object is not touched.
- R5: Mask bits: bit 0 is the direction (1 = staging to object), bit 1 selects arbitration, bit 2 selects control, bit 3 selects payload. In the write direction only the selected fields of the object change.
- R6: Writing an all-zero arbitration word into an object clears its valid bit (arbitration bit 31), so obj_valid for that object reads 0.
- R7: In the read direction the selected fields of the object are loaded into staging, and unselected staging registers keep their values.
- R8: Mask bit 4 in the read direction clears the object's new-data flag (control bit 15). The staging control register receives the value from before the clear.
- R9: Mask bit 5 in the read direction clears the object's interrupt-pending flag (control bit 14).
- R10: In the write direction mask bits 4 and 5 have no effect. The flags change only through a selected control word.
- R11: A pulse on status_evt sets status_irq. A host read of register 6 clears it, unless an event arrives in the same cycle, in which case the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (used only for the status acknowledge) |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr |
| status_evt | input | 1 | Status event pulse |
| status_irq | output | 1 | Pending status interrupt |
| xfer_busy | output | 1 | Transfer in progress |
| obj_valid | output | NUM_OBJ | Valid bit of each object |
| obj_newdat | output | NUM_OBJ | New-data flag of each object |
| obj_pend | output | NUM_OBJ | Interrupt-pending flag of each object |

## Verification
The assertions check the following on every cycle:
- busy rises only on a request write and falls on the cycle after the transfer strobe;
- an out-of-range request leaves busy low;
- the object index is held for the whole transfer;
- a zero arbitration write drops the valid bit;
- the read-direction flag clears reach the addressed flag vector bit;
- the status interrupt sets and acknowledges correctly.

Other behaviours need the bench scenarios. These are the exact busy length, the effect of a second request on an object that must stay untouched, unselected staging registers surviving a read, write-direction flag bits being ignored, and the pre-clear value landing in staging.

// File: rtl/mo_xfer_pkg.sv
package mo_xfer_pkg;

  localparam int ARB_W  = 32;
  localparam int CTL_W  = 16;
  localparam int DATA_W = 64;

  localparam int ARB_VALID_BIT  = 31;
  localparam int CTL_NEWDAT_BIT = 15;
  localparam int CTL_PEND_BIT   = 14;

  typedef enum logic [2:0] {
    A_REQ  = 3'd0,
    A_MASK = 3'd1,
    A_ARB  = 3'd2,
    A_CTL  = 3'd3,
    A_DLO  = 3'd4,
    A_DHI  = 3'd5,
    A_STAT = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic clr_pend;
    logic newdat;
    logic sel_data;
    logic sel_ctl;
    logic sel_arb;
    logic wr_dir;
  } cmd_mask_t;

  function automatic logic num_in_range(logic [7:0] num, int unsigned n_obj);
    return (num != 8'd0) && (32'(num) <= n_obj);
  endfunction

  function automatic logic [CTL_W-1:0] clear_flags(logic [CTL_W-1:0] ctl,
                                                   logic drop_newdat,
                                                   logic drop_pend);
    logic [CTL_W-1:0] r;
    r = ctl;
    if (drop_newdat) r[CTL_NEWDAT_BIT] = 1'b0;
    if (drop_pend)   r[CTL_PEND_BIT]   = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/mo_xfer_ctrl.sv
module mo_xfer_ctrl
  import mo_xfer_pkg::*;
#(
  parameter int NUM_OBJ     = 32,
  parameter int XFER_CYCLES = 3,
  localparam int IDX_W = $clog2(NUM_OBJ),
  localparam int CNT_W = $clog2(XFER_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_wr,
  input  logic [7:0]       req_num,
  input  cmd_mask_t        mask_in,
  output logic             busy,
  output logic             fire,
  output logic [IDX_W-1:0] obj_idx,
  output logic [7:0]       last_num,
  output cmd_mask_t        mask_q
);

  logic [CNT_W-1:0] cnt;
  logic             accept;

  assign accept = req_wr && !busy && num_in_range(req_num, NUM_OBJ);
  assign fire   = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      obj_idx  <= '0;
      last_num <= '0;
      mask_q   <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      cnt      <= CNT_W'(XFER_CYCLES - 1);
      obj_idx  <= IDX_W'(req_num - 8'd1);
      last_num <= req_num;
      mask_q   <= mask_in;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assert_busy_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_wr));
  assert_busy_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !busy);
  assert_bad_num_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !busy && !num_in_range(req_num, NUM_OBJ)) |=> !busy);
  assert_hold_obj_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fire) |=> (busy && $stable(obj_idx) && $stable(last_num)));

endmodule

// File: rtl/mo_obj_ram.sv
module mo_obj_ram
  import mo_xfer_pkg::*;
#(
  parameter int NUM_OBJ = 32,
  localparam int IDX_W = $clog2(NUM_OBJ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [IDX_W-1:0]  idx,
  input  cmd_mask_t         mask,
  input  logic [ARB_W-1:0]  stg_arb,
  input  logic [CTL_W-1:0]  stg_ctl,
  input  logic [DATA_W-1:0] stg_data,
  output logic [ARB_W-1:0]  rd_arb,
  output logic [CTL_W-1:0]  rd_ctl,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_OBJ-1:0] valid_vec,
  output logic [NUM_OBJ-1:0] newdat_vec,
  output logic [NUM_OBJ-1:0] pend_vec
);

  logic [ARB_W-1:0]  arb_mem  [NUM_OBJ];
  logic [CTL_W-1:0]  ctl_mem  [NUM_OBJ];
  logic [DATA_W-1:0] data_mem [NUM_OBJ];

  always_ff @(posedge clk) begin
    if (fire) begin
      if (mask.wr_dir) begin
        if (mask.sel_arb)  arb_mem[idx]  <= stg_arb;
        if (mask.sel_ctl)  ctl_mem[idx]  <= stg_ctl;
        if (mask.sel_data) data_mem[idx] <= stg_data;
      end else begin
        ctl_mem[idx] <= clear_flags(ctl_mem[idx], mask.newdat, mask.clr_pend);
      end
    end
  end

  assign rd_arb  = arb_mem[idx];
  assign rd_ctl  = ctl_mem[idx];
  assign rd_data = data_mem[idx];

  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_flags
    assign valid_vec[g]  = arb_mem[g][ARB_VALID_BIT];
    assign newdat_vec[g] = ctl_mem[g][CTL_NEWDAT_BIT];
    assign pend_vec[g]   = ctl_mem[g][CTL_PEND_BIT];
  end

  assert_zero_arb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mask.wr_dir && mask.sel_arb && stg_arb == '0) |=> !valid_vec[$past(idx)]);
  assert_newdat_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mask.wr_dir && mask.newdat) |=> !newdat_vec[$past(idx)]);
  assert_pend_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !mask.wr_dir && mask.clr_pend) |=> !pend_vec[$past(idx)]);
  assert_wr_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mask.wr_dir && !mask.sel_ctl) |=> ($stable(newdat_vec) && $stable(pend_vec)));

endmodule

// File: rtl/mo_host_regs.sv
module mo_host_regs
  import mo_xfer_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [2:0]        host_addr,
  input  logic [31:0]       host_wdata,
  input  logic              status_evt,
  input  logic              busy,
  input  logic [7:0]        last_num,
  input  logic              fire,
  input  cmd_mask_t         mask_q,
  input  logic [ARB_W-1:0]  rd_arb,
  input  logic [CTL_W-1:0]  rd_ctl,
  input  logic [DATA_W-1:0] rd_data,
  output cmd_mask_t         mask_reg,
  output logic [ARB_W-1:0]  stg_arb,
  output logic [CTL_W-1:0]  stg_ctl,
  output logic [DATA_W-1:0] stg_data,
  output logic [31:0]       host_rdata,
  output logic              status_irq
);

  logic load_back;
  logic stat_ack;

  assign load_back = fire && !mask_q.wr_dir;
  assign stat_ack  = host_rd && (host_addr == 3'(A_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_reg   <= '0;
      stg_arb    <= '0;
      stg_ctl    <= '0;
      stg_data   <= '0;
      status_irq <= 1'b0;
    end else begin
      if (host_wr) begin
        case (host_addr)
          3'(A_MASK): mask_reg       <= cmd_mask_t'(host_wdata[5:0]);
          3'(A_ARB):  stg_arb        <= host_wdata;
          3'(A_CTL):  stg_ctl        <= host_wdata[CTL_W-1:0];
          3'(A_DLO):  stg_data[31:0]  <= host_wdata;
          3'(A_DHI):  stg_data[63:32] <= host_wdata;
          default: ;
        endcase
      end
      if (load_back) begin
        if (mask_q.sel_arb)  stg_arb  <= rd_arb;
        if (mask_q.sel_ctl)  stg_ctl  <= rd_ctl;
        if (mask_q.sel_data) stg_data <= rd_data;
      end
      if (status_evt)    status_irq <= 1'b1;
      else if (stat_ack) status_irq <= 1'b0;
    end
  end

  always_comb begin
    case (host_addr)
      3'(A_REQ):  host_rdata = {16'h0, busy, 7'h0, last_num};
      3'(A_MASK): host_rdata = {26'h0, mask_reg};
      3'(A_ARB):  host_rdata = stg_arb;
      3'(A_CTL):  host_rdata = {16'h0, stg_ctl};
      3'(A_DLO):  host_rdata = stg_data[31:0];
      3'(A_DHI):  host_rdata = stg_data[63:32];
      3'(A_STAT): host_rdata = {31'h0, status_irq};
      default:    host_rdata = '0;
    endcase
  end

  assert_read_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_back && mask_q.sel_arb) |=> (stg_arb == $past(rd_arb)));
  assert_stat_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    status_evt |=> status_irq);
  assert_stat_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ack && !status_evt) |=> !status_irq);

endmodule

// File: rtl/mo_xfer_engine.sv
module mo_xfer_engine
  import mo_xfer_pkg::*;
#(
  parameter int NUM_OBJ     = 32,
  parameter int XFER_CYCLES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic               host_rd,
  input  logic [2:0]         host_addr,
  input  logic [31:0]        host_wdata,
  output logic [31:0]        host_rdata,
  input  logic               status_evt,
  output logic               status_irq,
  output logic               xfer_busy,
  output logic [NUM_OBJ-1:0] obj_valid,
  output logic [NUM_OBJ-1:0] obj_newdat,
  output logic [NUM_OBJ-1:0] obj_pend
);

  localparam int IDX_W = $clog2(NUM_OBJ);

  logic              req_wr;
  logic              fire;
  logic [IDX_W-1:0]  obj_idx;
  logic [7:0]        last_num;
  cmd_mask_t         mask_reg;
  cmd_mask_t         mask_q;
  logic [ARB_W-1:0]  stg_arb, rd_arb;
  logic [CTL_W-1:0]  stg_ctl, rd_ctl;
  logic [DATA_W-1:0] stg_data, rd_data;

  assign req_wr = host_wr && (host_addr == 3'(A_REQ));

  mo_xfer_ctrl #(.NUM_OBJ(NUM_OBJ), .XFER_CYCLES(XFER_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_wr   (req_wr),
    .req_num  (host_wdata[7:0]),
    .mask_in  (mask_reg),
    .busy     (xfer_busy),
    .fire     (fire),
    .obj_idx  (obj_idx),
    .last_num (last_num),
    .mask_q   (mask_q)
  );

  mo_obj_ram #(.NUM_OBJ(NUM_OBJ)) u_ram (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (fire),
    .idx        (obj_idx),
    .mask       (mask_q),
    .stg_arb    (stg_arb),
    .stg_ctl    (stg_ctl),
    .stg_data   (stg_data),
    .rd_arb     (rd_arb),
    .rd_ctl     (rd_ctl),
    .rd_data    (rd_data),
    .valid_vec  (obj_valid),
    .newdat_vec (obj_newdat),
    .pend_vec   (obj_pend)
  );

  mo_host_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .status_evt (status_evt),
    .busy       (xfer_busy),
    .last_num   (last_num),
    .fire       (fire),
    .mask_q     (mask_q),
    .rd_arb     (rd_arb),
    .rd_ctl     (rd_ctl),
    .rd_data    (rd_data),
    .mask_reg   (mask_reg),
    .stg_arb    (stg_arb),
    .stg_ctl    (stg_ctl),
    .stg_data   (stg_data),
    .host_rdata (host_rdata),
    .status_irq (status_irq)
  );

endmodule

// File: tb/mo_xfer_engine_bench.sv
module mo_xfer_engine_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 32;
  localparam int XFER = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [31:0] host_wdata = 32'd0;
  logic        status_evt = 1'b0;
  logic [31:0] host_rdata;
  logic        status_irq;
  logic        xfer_busy;
  logic [N-1:0] obj_valid, obj_newdat, obj_pend;

  int checks = 0;
  int fails  = 0;
  bit vec_known = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mo_xfer_engine u_mo_xfer_engine (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .status_evt(status_evt), .status_irq(status_irq), .xfer_busy(xfer_busy),
    .obj_valid(obj_valid), .obj_newdat(obj_newdat), .obj_pend(obj_pend)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_arb [N];
  logic [15:0] m_ctl [N];
  logic [31:0] m_dlo [N];
  logic [31:0] m_dhi [N];
  logic [31:0] s_arb, s_dlo, s_dhi;
  logic [15:0] s_ctl;
  logic [5:0]  s_mask, m_mask;
  logic [7:0]  m_num;
  int          m_idx, m_cnt;
  bit          m_busy, m_stat, m_fire;

  always @(posedge clk) begin
    if (!rst_n) begin
      s_arb = 0; s_ctl = 0; s_dlo = 0; s_dhi = 0; s_mask = 0; m_mask = 0;
      m_num = 0; m_idx = 0; m_cnt = 0; m_busy = 0; m_stat = 0;
    end else begin
      m_fire = m_busy && (m_cnt == 0);
      if (m_fire && m_mask[0]) begin
        if (m_mask[1]) m_arb[m_idx] = s_arb;
        if (m_mask[2]) m_ctl[m_idx] = s_ctl;
        if (m_mask[3]) begin m_dlo[m_idx] = s_dlo; m_dhi[m_idx] = s_dhi; end
      end
      if (host_wr) begin
        case (host_addr)
          3'd1: s_mask = host_wdata[5:0];
          3'd2: s_arb  = host_wdata;
          3'd3: s_ctl  = host_wdata[15:0];
          3'd4: s_dlo  = host_wdata;
          3'd5: s_dhi  = host_wdata;
          default: ;
        endcase
      end
      if (m_fire && !m_mask[0]) begin
        if (m_mask[1]) s_arb = m_arb[m_idx];
        if (m_mask[2]) s_ctl = m_ctl[m_idx];
        if (m_mask[3]) begin s_dlo = m_dlo[m_idx]; s_dhi = m_dhi[m_idx]; end
        if (m_mask[4]) m_ctl[m_idx][15] = 1'b0;
        if (m_mask[5]) m_ctl[m_idx][14] = 1'b0;
      end
      if (status_evt) m_stat = 1;
      else if (host_rd && host_addr == 3'd6) m_stat = 0;
      if (m_busy) begin
        if (m_cnt == 0) m_busy = 0;
        else m_cnt = m_cnt - 1;
      end else if (host_wr && host_addr == 3'd0 &&
                   host_wdata[7:0] >= 8'd1 && host_wdata[7:0] <= 8'(N)) begin
        m_busy = 1; m_cnt = XFER - 1;
        m_idx = int'(host_wdata[7:0]) - 1;
        m_num = host_wdata[7:0];
        m_mask = s_mask;
      end
    end
  end

  function automatic logic [31:0] m_rdata(logic [2:0] a);
    case (a)
      3'd0: return {16'h0, m_busy, 7'h0, m_num};
      3'd1: return {26'h0, s_mask};
      3'd2: return s_arb;
      3'd3: return {16'h0, s_ctl};
      3'd4: return s_dlo;
      3'd5: return s_dhi;
      3'd6: return {31'h0, m_stat};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison, a quarter period after the edge
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_n) begin
      logic [N-1:0] ev, en, ep;
      chk("R2 busy vs model", 64'(xfer_busy), 64'(m_busy));
      chk("R11 irq vs model", 64'(status_irq), 64'(m_stat));
      chk("R7 rdata vs model", 64'(host_rdata), 64'(m_rdata(host_addr)));
      if (vec_known) begin
        for (int i = 0; i < N; i++) begin
          ev[i] = m_arb[i][31]; en[i] = m_ctl[i][15]; ep[i] = m_ctl[i][14];
        end
        chk("R5 valid vec vs model", 64'(obj_valid), 64'(ev));
        chk("R8 newdat vec vs model", 64'(obj_newdat), 64'(en));
        chk("R9 pend vec vs model", 64'(obj_pend), 64'(ep));
      end
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_wdata = 32'd0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20 && xfer_busy; k++) @(negedge clk);
  endtask

  task automatic xfer(int num);
    wr(3'd0, 32'(num));
    wait_idle();
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    host_addr = a;
    #1 chk(tag, 64'(host_rdata), 64'(exp));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    checks++; fails++;
    $display("FAIL R2 watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 busy after reset", 64'(xfer_busy), 64'd0);
    chk("R1 irq after reset", 64'(status_irq), 64'd0);
    for (int a = 0; a < 7; a++) rd_chk(3'(a), 32'h0, "R1 register after reset");

    // sweep: zero arb/ctl into every object, then clear flags by read
    wr(3'd1, 32'h07); wr(3'd2, 32'h0); wr(3'd3, 32'h0);
    for (int n = 1; n <= N; n++) xfer(n);
    wr(3'd1, 32'h30);
    for (int n = 1; n <= N; n++) xfer(n);
    vec_known = 1'b1;
    #1;
    chk("R6 all objects invalid after sweep", 64'(obj_valid), 64'd0);
    chk("R9 all pend clear after sweep", 64'(obj_pend), 64'd0);
    chk("R8 all newdat clear after sweep", 64'(obj_newdat), 64'd0);

    // R2: busy length
    begin
      int len = 0;
      wr(3'd0, 32'd5);
      while (xfer_busy && len < 20) begin len++; @(negedge clk); end
      chk("R2 busy cycles", 64'(len), 64'(XFER));
    end

    // R4: second request while busy ignored
    wr(3'd1, 32'h07); wr(3'd2, 32'h8000_0007); wr(3'd3, 32'h0);
    wr(3'd0, 32'd7);
    wr(3'd0, 32'd9);
    wait_idle();
    chk("R4 object 7 written", 64'(obj_valid[6]), 64'd1);
    chk("R4 object 9 untouched", 64'(obj_valid[8]), 64'd0);
    rd_chk(3'd0, 32'h7, "R4 request keeps first number");

    // R3: out-of-range numbers
    wr(3'd0, 32'd0);
    chk("R3 number 0 no busy", 64'(xfer_busy), 64'd0);
    wr(3'd0, 32'd33);
    chk("R3 number 33 no busy", 64'(xfer_busy), 64'd0);
    rd_chk(3'd0, 32'h7, "R3 request number unchanged");

    // R5: write all fields, then payload only
    wr(3'd1, 32'h0F); wr(3'd2, 32'h8000_0123); wr(3'd3, 32'hC00A);
    wr(3'd4, 32'h1111_2222); wr(3'd5, 32'h3333_4444);
    xfer(3);
    chk("R5 valid set", 64'(obj_valid[2]), 64'd1);
    chk("R5 newdat set", 64'(obj_newdat[2]), 64'd1);
    chk("R5 pend set", 64'(obj_pend[2]), 64'd1);
    wr(3'd1, 32'h09); wr(3'd2, 32'h0); wr(3'd4, 32'hAAAA_5555);
    xfer(3);
    chk("R5 unselected arb kept", 64'(obj_valid[2]), 64'd1);

    // R7 / R8: read back with newdat clear
    wr(3'd2, 32'h0); wr(3'd3, 32'h0); wr(3'd4, 32'h0); wr(3'd5, 32'h0);
    wr(3'd1, 32'h1E);
    xfer(3);
    rd_chk(3'd2, 32'h8000_0123, "R7 arb loaded");
    rd_chk(3'd3, 32'hC00A, "R8 ctl shows pre-clear flags");
    rd_chk(3'd4, 32'hAAAA_5555, "R7 payload low loaded");
    rd_chk(3'd5, 32'h3333_4444, "R7 payload high loaded");
    chk("R8 newdat cleared", 64'(obj_newdat[2]), 64'd0);
    chk("R8 pend untouched", 64'(obj_pend[2]), 64'd1);

    // R7: unselected staging survives a read
    wr(3'd4, 32'h55); wr(3'd1, 32'h02);
    xfer(3);
    rd_chk(3'd4, 32'h55, "R7 unselected payload kept");

    // R9: pend clear by read
    wr(3'd1, 32'h20);
    xfer(3);
    chk("R9 pend cleared", 64'(obj_pend[2]), 64'd0);
    rd_chk(3'd3, 32'hC00A, "R9 staging ctl not reloaded");

    // R10: flag bits ignored in write direction
    wr(3'd1, 32'h35); wr(3'd3, 32'h4000);
    xfer(4);
    chk("R10 newdat from ctl word", 64'(obj_newdat[3]), 64'd0);
    chk("R10 pend from ctl word", 64'(obj_pend[3]), 64'd1);
    wr(3'd1, 32'h33); wr(3'd2, 32'h8000_0004);
    xfer(4);
    chk("R10 pend kept on write with clear bit", 64'(obj_pend[3]), 64'd1);

    // R6: zero arbitration invalidates
    wr(3'd1, 32'h03); wr(3'd2, 32'h0);
    xfer(3);
    chk("R6 valid cleared", 64'(obj_valid[2]), 64'd0);

    // R11: status event and acknowledge
    @(negedge clk); status_evt = 1'b1;
    @(negedge clk); status_evt = 1'b0;
    chk("R11 irq set", 64'(status_irq), 64'd1);
    rd_chk(3'd6, 32'h1, "R11 status reads pending");
    @(negedge clk); host_rd = 1'b1; host_addr = 3'd6;
    @(negedge clk); host_rd = 1'b0;
    chk("R11 irq acknowledged", 64'(status_irq), 64'd0);

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule